// File: doc/BRIEF.md
# Falling-Edge Launched Gap-and-Width Pulser

This block derives a secondary pulse train from a primary PWM waveform generated elsewhere. Each falling edge of the primary input starts a short chain of two one-shots. The first one-shot counts a programmable gap in clock cycles. When the gap has elapsed, the second one-shot drives the secondary output high for a programmable width in clock cycles. Because the secondary pulse always begins after the primary pulse has ended, the two trains interleave without overlap at repetition rates from about 1 kHz to 300 kHz and primary duty from 1% to 99%, provided the gap and width fit inside the primary's low time.

The primary input passes through a two-flop synchronizer before edge detection. Gap and width are captured at the trigger, so software or a neighbouring block can recompute them for the next period while a sequence runs. A busy flag covers the whole sequence. If the primary rises again while the secondary is still high, a sticky error flag reports the overlap until the next reset.

Top module: `edge_chain_pulser`

## Requirements
- R1: While reset is applied and after it is released, with no primary falling edge yet, `sec_o`, `busy_o` and `overlap_err_o` are all 0.
- R2: A primary falling edge is detected after synchronization: if `prim_i` is first sampled low at clock edge k, having been sampled high at edge k-1, `busy_o` is high after edge k+2. A rising edge alone never starts a sequence.
- R3: With a captured gap G greater than 0, `sec_o` rises exactly G clock cycles after `busy_o` rises.
- R4: With a captured gap of 0, `sec_o` rises in the same cycle as `busy_o`.
- R5: `sec_o` stays high for exactly W consecutive cycles, where W is the captured width; a width of 0 gives a 1-cycle pulse.
- R6: `busy_o` is high from the trigger until `sec_o` falls, and falls in the same cycle as `sec_o`; `sec_o` is never high while `busy_o` is low.
- R7: A primary falling edge seen while `busy_o` is high is ignored: it neither restarts nor extends the running sequence, and starts no new one.
- R8: `gap_i` and `width_i` are sampled only at the triggering edge; changing them during a sequence does not alter the gap or width of that sequence.
- R9: When a synchronized primary rising edge is detected while `sec_o` is high, `overlap_err_o` goes high one cycle later and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prim_i | input | 1 | Primary PWM input, asynchronous to `clk` |
| gap_i | input | CNT_W | Gap from primary fall to secondary rise, in clock cycles |
| width_i | input | CNT_W | Secondary pulse width in clock cycles (0 acts as 1) |
| sec_o | output | 1 | Secondary pulse output |
| busy_o | output | 1 | High while a gap or pulse is in progress |
| overlap_err_o | output | 1 | Sticky flag: primary rose while the secondary was high |

## Verification
A wrong state or counter value shows at the ports within one sequence. A bad gap count moves the rising edge of `sec_o` relative to `busy_o`. A bad width count changes how long `sec_o` stays high. A stuck state keeps `busy_o` high past the expected end, or never raises it. A missed or wrongly accepted trigger shows up as an extra or missing pulse one synchronizer delay after the primary falls. The bench compares all three outputs on every cycle against an event-time model, so any such error appears in the first cycle where the outputs differ.

// File: rtl/ecp_pkg.sv
package ecp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_GAP   = 2'd1,
    ST_PULSE = 2'd2
  } ecp_state_e;
endpackage

// File: rtl/ecp_rst_sync.sv
module ecp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = rst_q[STAGES-1];
endmodule

// File: rtl/ecp_sync.sv
module ecp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], d_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = prev_q & ~chain_q[STAGES-1];
  assign rise_o = ~prev_q & chain_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o); // R2
endmodule

// File: rtl/ecp_ctrl.sv
module ecp_ctrl
  import ecp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             sec_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  ecp_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W-1:0] wid_q, wid_n;
  logic             cnt_en, wid_en;
  logic [CNT_W-1:0] wid_m1;

  // width of 0 is treated as a single cycle
  assign wid_m1 = (width_i == '0) ? '0 : (width_i - ONE);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    wid_n  = wid_q;
    cnt_en = 1'b0;
    wid_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fall_i) begin
          wid_en = 1'b1;
          wid_n  = wid_m1;
          cnt_en = 1'b1;
          if (gap_i == '0) begin
            st_n  = ST_PULSE;
            cnt_n = wid_m1;
          end else begin
            st_n  = ST_GAP;
            cnt_n = gap_i - ONE;
          end
        end
      end
      ST_GAP: begin
        cnt_en = 1'b1;
        if (cnt_q == '0) begin
          st_n  = ST_PULSE;
          cnt_n = wid_q;
        end else begin
          cnt_n = cnt_q - ONE;
        end
      end
      ST_PULSE: begin
        if (cnt_q == '0) begin
          st_n = ST_IDLE;
        end else begin
          cnt_en = 1'b1;
          cnt_n  = cnt_q - ONE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      wid_q <= '0;
    end else begin
      st_q <= st_n;
      if (cnt_en) cnt_q <= cnt_n;
      if (wid_en) wid_q <= wid_n;
    end
  end

  assign sec_o  = (st_q == ST_PULSE);
  assign busy_o = (st_q != ST_IDLE);

  AST_SEC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_o |-> busy_o); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !fall_i) |=> (st_q == ST_IDLE)); // R2
  AST_ZERO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && fall_i && gap_i == '0) |=> sec_o); // R4
  AST_PULSE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PULSE && cnt_q != '0) |=> sec_o); // R5
  AST_BUSY_IGNORES_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && fall_i) |=> $stable(wid_q)); // R7
endmodule

// File: rtl/ecp_flag.sv
module ecp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |=> flag_o); // R9
endmodule

// File: rtl/edge_chain_pulser.sv
module edge_chain_pulser #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prim_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic [CNT_W-1:0] width_i,
  output logic             sec_o,
  output logic             busy_o,
  output logic             overlap_err_o
);
  logic rst_n_s;
  logic prim_lvl, prim_fall, prim_rise;
  logic overlap_set;

  ecp_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  ecp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .d_i    (prim_i),
    .lvl_o  (prim_lvl),
    .fall_o (prim_fall),
    .rise_o (prim_rise)
  );

  ecp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .fall_i  (prim_fall),
    .gap_i   (gap_i),
    .width_i (width_i),
    .sec_o   (sec_o),
    .busy_o  (busy_o)
  );

  assign overlap_set = prim_rise & sec_o;

  ecp_flag u_err (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_i  (overlap_set),
    .flag_o (overlap_err_o)
  );

  AST_OVERLAP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (prim_rise && sec_o) |=> overlap_err_o); // R9
  AST_NO_FALL_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n_s)
    prim_lvl |-> !prim_fall); // R2
endmodule

// File: tb/edge_chain_pulser_bench.sv
module edge_chain_pulser_bench;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             prim = 1'b0;
  logic [CNT_W-1:0] gap = '0;
  logic [CNT_W-1:0] wid = '0;
  logic             sec, busy, err;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  bit          model_on = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  edge_chain_pulser #(.CNT_W(CNT_W)) u_edge_chain_pulser (
    .clk           (clk),
    .rst_n         (rst_n),
    .prim_i        (prim),
    .gap_i         (gap),
    .width_i       (wid),
    .sec_o         (sec),
    .busy_o        (busy),
    .overlap_err_o (err)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint eff_w(input int w);
    return (w == 0) ? 1 : longint'(w);
  endfunction

  // event-time reference model, updated at each rising edge
  bit     m1, m2, m3, act;
  longint n, t_start, t_sec, t_end;
  bit     e_sec, e_busy, e_err;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 = 0; m2 = 0; m3 = 0; act = 0; n = 0;
      e_sec = 0; e_busy = 0; e_err = 0;
    end else begin
      bit f, r, sec_prev, idle;
      f = m3 & ~m2;
      r = m2 & ~m3;
      sec_prev = e_sec;
      n++;
      idle = !(act && n <= t_end + 1);
      if (idle && f) begin
        act = 1;
        t_start = n;
        t_sec = n + longint'(gap);
        t_end = t_sec + eff_w(int'(wid)) - 1;
      end
      e_busy = act && n >= t_start && n <= t_end;
      e_sec  = act && n >= t_sec && n <= t_end;
      if (r && sec_prev) e_err = 1;
      m3 = m2; m2 = m1; m1 = prim;
    end
  end

  always @(negedge clk) begin
    if (model_on) begin
      check("R3/R4/R5 sec_o", int'(sec), int'(e_sec));
      check("R6/R7 busy_o", int'(busy), int'(e_busy));
      check("R9 overlap_err_o", int'(err), int'(e_err));
    end
  end

  task automatic do_reset();
    @(negedge clk);
    prim = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 sec in reset", int'(sec), 0);
    check("R1 busy in reset", int'(busy), 0);
    check("R1 err in reset", int'(err), 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    check("R1 sec after reset", int'(sec), 0);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 err after reset", int'(err), 0);
  endtask

  task automatic run_seq(input int g, input int w, input bit change_mid,
                         output int t_busy, output int t_s, output int t_w,
                         output int busy_end);
    @(negedge clk);
    gap = CNT_W'(g);
    wid = CNT_W'(w);
    prim = 1;
    repeat (4) @(negedge clk);
    prim = 0;
    t_busy = 0;
    do begin
      @(negedge clk);
      t_busy++;
    end while (!busy && t_busy < 20);
    if (change_mid) begin
      gap = CNT_W'(g + 7);
      wid = CNT_W'(w + 9);
    end
    t_s = 0;
    while (!sec && t_s < 2000) begin
      @(negedge clk);
      t_s++;
    end
    t_w = 0;
    while (sec && t_w < 2000) begin
      @(negedge clk);
      t_w++;
    end
    busy_end = int'(busy);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #200us;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int tb, ts, tw, be;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    do_reset();
    model_on = 1;

    run_seq(3, 4, 0, tb, ts, tw, be);
    check("R2 sync latency", tb, 3);
    check("R3 gap 3", ts, 3);
    check("R5 width 4", tw, 4);
    check("R6 busy ends with sec", be, 0);

    run_seq(0, 6, 0, tb, ts, tw, be);
    check("R4 gap 0", ts, 0);
    check("R5 width 6", tw, 6);

    run_seq(2, 0, 0, tb, ts, tw, be);
    check("R5 width 0 as 1", tw, 1);

    run_seq(4, 5, 1, tb, ts, tw, be);
    check("R8 gap held", ts, 4);
    check("R8 width held", tw, 5);

    // R7: extra falling edge during the gap
    begin
      int hi_cnt, rises;
      bit last_busy;
      @(negedge clk);
      gap = CNT_W'(12);
      wid = CNT_W'(3);
      prim = 1;
      repeat (4) @(negedge clk);
      prim = 0;
      repeat (4) @(negedge clk);
      prim = 1;
      repeat (2) @(negedge clk);
      prim = 0;
      hi_cnt = 0;
      rises = 0;
      last_busy = 1;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (sec) hi_cnt++;
        if (busy && !last_busy) rises++;
        last_busy = busy;
      end
      check("R7 single pulse width", hi_cnt, 3);
      check("R7 no restart", rises, 0);
      check("R7 busy idle after", int'(busy), 0);
      check("R9 no error from gap rise", int'(err), 0);
    end

    // R2: rising edge alone starts nothing
    @(negedge clk);
    prim = 1;
    repeat (10) @(negedge clk);
    check("R2 rise no start", int'(busy), 0);
    prim = 0;
    repeat (30) @(negedge clk);

    // R9: overlap detection and stickiness
    @(negedge clk);
    gap = '0;
    wid = CNT_W'(20);
    prim = 1;
    repeat (4) @(negedge clk);
    prim = 0;
    repeat (5) @(negedge clk);
    check("R9 sec high before overlap", int'(sec), 1);
    prim = 1;
    repeat (5) @(negedge clk);
    check("R9 overlap flagged", int'(err), 1);
    prim = 0;
    repeat (50) @(negedge clk);
    check("R9 flag sticky", int'(err), 1);
    model_on = 0;
    do_reset();
    model_on = 1;

    // constrained random phase
    for (int p = 0; p < 120; p++) begin
      int per, hi;
      per = int'($urandom_range(8, 90));
      hi  = int'($urandom_range(1, per - 1));
      prim = 1;
      for (int c = 0; c < per; c++) begin
        if (c == hi) prim = 0;
        if ($urandom_range(0, 7) == 0) begin
          gap = CNT_W'($urandom_range(0, 25));
          wid = CNT_W'($urandom_range(0, 30));
        end
        @(negedge clk);
      end
    end
    prim = 0;
    repeat (80) @(negedge clk);
    model_on = 0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule